// File: doc/BRIEF.md
# Cycle-Stealing Block Transfer Engine

This block moves a programmed number of words between its own peripheral and system memory without the processor touching each word. Software sets an address, a word count, a direction and a device select through a small register port, then starts the run. For every word the engine asks for the system bus, uses it for exactly one clock to write or read one memory location, and gives it back at once. The processor therefore loses only that single cycle per word, and sees no interrupt or context switch until the whole block is done.

The peripheral side is a pair of valid/ready streams holding at most one word inside the engine. In the device-to-memory direction the engine accepts a word on `dev_in_*` only when its buffer is empty, and requests the bus only when the buffer holds a word. In the memory-to-device direction it requests the bus only when the buffer is empty, captures the read data in the stolen cycle, then offers the word on `dev_out_*` and holds it stable until the device takes it. The memory address advances and the remaining count falls by one on each stolen cycle. When the count is spent and the buffer is empty, the engine drops busy and raises `irq`, which stays high until software reads the status register.

Top module: `csdma_ctrl`

## Requirements
- R1: After reset `irq`, `bus_req`, `dev_in_ready` and `dev_out_valid` are low and reads at offsets 0, 1 and 2 return zero.
- R2: While idle, a write at offset 1 loads the memory address and a write at offset 2 loads the word count, each reading back unchanged. A write at offset 0 sets direction from bit 0 (0 = device to memory, 1 = memory to device), the device select from bits [2 +: DEV_W] (driven on `dev_sel`), and starts a run when bit 1 is set. A read at offset 0 returns busy in bit 0 and the interrupt flag in bit 1.
- R3: `bus_req` stays high until `bus_gnt`; the word moves in the cycle where both are high, the only cycle with `bus_stb` high; `bus_addr`, `bus_wdata` and `bus_we` are zero outside it; `bus_req` is low in the cycle after each stolen cycle.
- R4: Device to memory: the words accepted on `dev_in` are written in order to consecutive addresses from the programmed address, modulo 2^W, exactly count words.
- R5: Memory to device: consecutive addresses from the programmed address are read and the words are offered on `dev_out` in the same order, exactly count words.
- R6: `dev_out_valid` and `dev_out_data` hold until `dev_out_ready`; no bus request is made while a word waits for the device; `dev_in_ready` is low while a word waits for the bus.
- R7: Each stolen cycle adds one to the address and takes one from the count; after a run the address reads start plus count (modulo 2^W) and the count reads zero.
- R8: `irq` rises two sampled cycles after the cycle of the final word event (last stolen cycle toward memory, last device handshake toward the device), stays high until a status read, and that read returns it set while clearing it.
- R9: A start with a count of zero sets `irq` on the start edge, never sets busy and makes no bus request.
- R10: Register writes while busy are ignored: address, count, direction and a new start have no effect on the running transfer or on read-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe (offset 0 read clears `irq`) |
| cfg_addr | input | 2 | Register offset |
| cfg_wdata | input | W | Register write data |
| cfg_rdata | output | W | Register read data, combinational |
| irq | output | 1 | Completion interrupt |
| dev_sel | output | DEV_W | Programmed device select |
| dev_in_valid | input | 1 | Device word offered to the engine |
| dev_in_ready | output | 1 | Engine can take a device word |
| dev_in_data | input | W | Device word |
| dev_out_valid | output | 1 | Engine offers a memory word to the device |
| dev_out_ready | input | 1 | Device takes the offered word |
| dev_out_data | output | W | Memory word for the device |
| bus_req | output | 1 | System bus request |
| bus_gnt | input | 1 | System bus grant |
| bus_stb | output | 1 | Stolen-cycle strobe |
| bus_we | output | 1 | Stolen cycle is a memory write |
| bus_addr | output | W | Memory address during the stolen cycle |
| bus_wdata | output | W | Memory write data during the stolen cycle |
| bus_rdata | input | W | Memory read data, sampled in the stolen cycle |

## Verification
A register write or start lands on the edge after the strobe, so read-back and `dev_sel` are sampled at the following falling edge. A bus request appears in the same cycle the buffer condition is met, the memory word moves on the edge ending the cycle where grant meets request, and the bench checks address, data and the forced request gap at the falling edge of that cycle and the next. The interrupt is due exactly two falling edges after the final word event; the bench counts cycles from a free-running counter read only at falling edges and compares against that offset, then reads the status twice to see the flag returned and then cleared.

// File: rtl/csdma_pkg.sv
package csdma_pkg;

  typedef enum logic {
    DIR_TO_MEM = 1'b0,
    DIR_TO_DEV = 1'b1
  } dir_e;

  localparam logic [1:0] OFS_CTRL = 2'd0;
  localparam logic [1:0] OFS_ADDR = 2'd1;
  localparam logic [1:0] OFS_CNT  = 2'd2;

  localparam int CTRL_DIR_BIT = 0;
  localparam int CTRL_GO_BIT  = 1;
  localparam int CTRL_DEV_LSB = 2;

  localparam int ST_BUSY_BIT = 0;
  localparam int ST_IRQ_BIT  = 1;

endpackage

// File: rtl/csdma_regs.sv
module csdma_regs
  import csdma_pkg::*;
#(
  parameter int W     = 8,
  parameter int DEV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_rd,
  input  logic [1:0]       cfg_addr,
  input  logic [W-1:0]     cfg_wdata,
  output logic [W-1:0]     cfg_rdata,
  input  logic             busy,
  input  logic [W-1:0]     cur_addr,
  input  logic [W-1:0]     cur_cnt,
  input  logic             done_evt,
  output logic             ld_addr,
  output logic             ld_cnt,
  output logic             start,
  output dir_e             dir,
  output logic [DEV_W-1:0] dev_sel,
  output logic             irq
);

  logic idle_wr;
  logic ctrl_wr;
  logic stat_rd;

  assign idle_wr = cfg_wr && !busy;
  assign ctrl_wr = idle_wr && (cfg_addr == OFS_CTRL);
  assign ld_addr = idle_wr && (cfg_addr == OFS_ADDR);
  assign ld_cnt  = idle_wr && (cfg_addr == OFS_CNT);
  assign start   = ctrl_wr && cfg_wdata[CTRL_GO_BIT];
  assign stat_rd = cfg_rd && (cfg_addr == OFS_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir     <= DIR_TO_MEM;
      dev_sel <= '0;
      irq     <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        dir     <= dir_e'(cfg_wdata[CTRL_DIR_BIT]);
        dev_sel <= cfg_wdata[CTRL_DEV_LSB +: DEV_W];
      end
      if (done_evt || (start && cur_cnt == '0))
        irq <= 1'b1;
      else if (stat_rd)
        irq <= 1'b0;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    unique case (cfg_addr)
      OFS_CTRL: begin
        cfg_rdata[ST_BUSY_BIT] = busy;
        cfg_rdata[ST_IRQ_BIT]  = irq;
      end
      OFS_ADDR: cfg_rdata = cur_addr;
      OFS_CNT:  cfg_rdata = cur_cnt;
      default:  cfg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/csdma_seq.sv
module csdma_seq
  import csdma_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_addr,
  input  logic         ld_cnt,
  input  logic [W-1:0] ld_val,
  input  logic         start,
  input  dir_e         dir,
  output logic         busy,
  output logic [W-1:0] cur_addr,
  output logic [W-1:0] cur_cnt,
  output logic         done_evt,
  input  logic         dev_in_valid,
  output logic         dev_in_ready,
  input  logic [W-1:0] dev_in_data,
  output logic         dev_out_valid,
  input  logic         dev_out_ready,
  output logic [W-1:0] dev_out_data,
  output logic         bus_req,
  input  logic         bus_gnt,
  output logic         bus_stb,
  output logic         bus_we,
  output logic [W-1:0] bus_addr,
  output logic [W-1:0] bus_wdata,
  input  logic [W-1:0] bus_rdata
);

  logic [W-1:0] addr_q;
  logic [W-1:0] cnt_q;
  logic [W-1:0] buf_q;
  logic         full_q;
  logic         busy_q;
  logic         words_left;
  logic         to_dev;
  logic         in_take;
  logic         out_take;

  assign words_left = (cnt_q != '0);
  assign to_dev     = (dir == DIR_TO_DEV);

  // Toward memory the buffer must hold a word; toward the device it must be empty.
  assign bus_req  = busy_q && words_left && (to_dev ? !full_q : full_q);
  assign bus_stb  = bus_req && bus_gnt;
  assign bus_we   = bus_stb && !to_dev;
  assign bus_addr = bus_stb ? addr_q : '0;
  assign bus_wdata = bus_we ? buf_q : '0;

  assign dev_in_ready  = busy_q && !to_dev && !full_q && words_left;
  assign dev_out_valid = busy_q && to_dev && full_q;
  assign dev_out_data  = buf_q;
  assign in_take       = dev_in_valid && dev_in_ready;
  assign out_take      = dev_out_valid && dev_out_ready;

  assign done_evt = busy_q && !words_left && !full_q;
  assign busy     = busy_q;
  assign cur_addr = addr_q;
  assign cur_cnt  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
      buf_q  <= '0;
      full_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      if (ld_addr) addr_q <= ld_val;
      if (ld_cnt)  cnt_q  <= ld_val;
      if (start) begin
        busy_q <= words_left;
        full_q <= 1'b0;
      end else if (done_evt) begin
        busy_q <= 1'b0;
      end
      if (bus_stb) begin
        addr_q <= addr_q + 1'b1;
        cnt_q  <= cnt_q - 1'b1;
        if (to_dev) begin
          buf_q  <= bus_rdata;
          full_q <= 1'b1;
        end else begin
          full_q <= 1'b0;
        end
      end else if (in_take) begin
        buf_q  <= dev_in_data;
        full_q <= 1'b1;
      end else if (out_take) begin
        full_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/csdma_ctrl.sv
module csdma_ctrl
  import csdma_pkg::*;
#(
  parameter int W     = 8,
  parameter int DEV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_rd,
  input  logic [1:0]       cfg_addr,
  input  logic [W-1:0]     cfg_wdata,
  output logic [W-1:0]     cfg_rdata,
  output logic             irq,
  output logic [DEV_W-1:0] dev_sel,
  input  logic             dev_in_valid,
  output logic             dev_in_ready,
  input  logic [W-1:0]     dev_in_data,
  output logic             dev_out_valid,
  input  logic             dev_out_ready,
  output logic [W-1:0]     dev_out_data,
  output logic             bus_req,
  input  logic             bus_gnt,
  output logic             bus_stb,
  output logic             bus_we,
  output logic [W-1:0]     bus_addr,
  output logic [W-1:0]     bus_wdata,
  input  logic [W-1:0]     bus_rdata
);

  logic         busy;
  logic [W-1:0] cur_addr;
  logic [W-1:0] cur_cnt;
  logic         done_evt;
  logic         ld_addr;
  logic         ld_cnt;
  logic         start;
  dir_e         dir;

  csdma_regs #(.W(W), .DEV_W(DEV_W)) i_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_rd    (cfg_rd),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .busy      (busy),
    .cur_addr  (cur_addr),
    .cur_cnt   (cur_cnt),
    .done_evt  (done_evt),
    .ld_addr   (ld_addr),
    .ld_cnt    (ld_cnt),
    .start     (start),
    .dir       (dir),
    .dev_sel   (dev_sel),
    .irq       (irq)
  );

  csdma_seq #(.W(W)) i_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .ld_addr       (ld_addr),
    .ld_cnt        (ld_cnt),
    .ld_val        (cfg_wdata),
    .start         (start),
    .dir           (dir),
    .busy          (busy),
    .cur_addr      (cur_addr),
    .cur_cnt       (cur_cnt),
    .done_evt      (done_evt),
    .dev_in_valid  (dev_in_valid),
    .dev_in_ready  (dev_in_ready),
    .dev_in_data   (dev_in_data),
    .dev_out_valid (dev_out_valid),
    .dev_out_ready (dev_out_ready),
    .dev_out_data  (dev_out_data),
    .bus_req       (bus_req),
    .bus_gnt       (bus_gnt),
    .bus_stb       (bus_stb),
    .bus_we        (bus_we),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata)
  );

endmodule

// File: rtl/csdma_chk.sv
module csdma_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cfg_rd,
  input logic [1:0]   cfg_addr,
  input logic         irq,
  input logic         dev_out_valid,
  input logic         dev_out_ready,
  input logic [W-1:0] dev_out_data,
  input logic         bus_req,
  input logic         bus_gnt,
  input logic         bus_stb,
  input logic         bus_we,
  input logic [W-1:0] bus_addr,
  input logic [W-1:0] bus_wdata
);

  // R3
  stb_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stb |=> !bus_req);

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> bus_req);

  // R3
  bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_stb |-> (bus_addr == '0 && bus_wdata == '0 && !bus_we));

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_out_valid && !dev_out_ready) |=> (dev_out_valid && $stable(dev_out_data)));

  // R6
  out_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_out_valid |-> !bus_req);

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(cfg_rd && cfg_addr == 2'd0)) |=> irq);

  // R8
  irq_quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> !bus_req);

endmodule

bind csdma_ctrl csdma_chk #(.W(W)) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_rd        (cfg_rd),
  .cfg_addr      (cfg_addr),
  .irq           (irq),
  .dev_out_valid (dev_out_valid),
  .dev_out_ready (dev_out_ready),
  .dev_out_data  (dev_out_data),
  .bus_req       (bus_req),
  .bus_gnt       (bus_gnt),
  .bus_stb       (bus_stb),
  .bus_we        (bus_we),
  .bus_addr      (bus_addr),
  .bus_wdata     (bus_wdata)
);

// File: tb/test_csdma_ctrl.sv
`timescale 1ns/1ps
module test_csdma_ctrl;
  localparam int W = 8;
  localparam int DEV_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [W-1:0] cfg_wdata = '0, cfg_rdata;
  logic irq;
  logic [DEV_W-1:0] dev_sel;
  logic dev_in_valid = 1'b0, dev_in_ready;
  logic [W-1:0] dev_in_data = '0;
  logic dev_out_valid, dev_out_ready = 1'b0;
  logic [W-1:0] dev_out_data;
  logic bus_req, bus_gnt = 1'b0, bus_stb, bus_we;
  logic [W-1:0] bus_addr, bus_wdata, bus_rdata;

  logic [W-1:0] mem [256];
  int checks = 0, fails = 0;
  int cyc = 0;
  int gdly = 0;
  int run_k = 0, run_dir = 0, run_n = 0;
  logic [W-1:0] run_start = '0;
  int nstb = 0, stb_cyc = 0, rx_cyc = 0;
  logic prev_stb = 1'b0;

  always #5 clk = ~clk;

  csdma_ctrl #(.W(W), .DEV_W(DEV_W)) i_csdma_ctrl (.*);

  assign bus_rdata = mem[bus_addr];

  initial for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
  always @(posedge clk) if (bus_stb && bus_we) mem[bus_addr] <= bus_wdata;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pat(input int k, input int i);
    return 8'(8'h5A ^ (k * 13 + i));
  endfunction

  // Grant responder: grants gdly cycles after a request appears.
  initial begin
    int wcnt = 0;
    forever begin
      @(negedge clk);
      if (bus_req) begin
        if (wcnt >= gdly) bus_gnt = 1'b1;
        else begin bus_gnt = 1'b0; wcnt++; end
      end else begin
        bus_gnt = 1'b0; wcnt = 0;
      end
    end
  end

  // Stolen-cycle monitor
  always @(negedge clk) begin
    if (prev_stb) chk(!bus_req, "R3 request gap", int'(bus_req), 0);
    if (bus_stb) begin
      chk(bus_addr == 8'(run_start + nstb), "R4/R5 address", bus_addr, 8'(run_start + nstb));
      chk(bus_we == (run_dir == 0), "R3 write flag", bus_we, int'(run_dir == 0));
      if (run_dir == 0)
        chk(bus_wdata == pat(run_k, nstb), "R4 write data", bus_wdata, pat(run_k, nstb));
      nstb++;
      stb_cyc = cyc;
    end
    prev_stb = bus_stb;
  end

  task automatic cfg_write(input logic [1:0] a, input logic [W-1:0] d);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(input logic [1:0] a, output logic [W-1:0] d);
    cfg_rd = 1'b1; cfg_addr = a;
    #1 d = cfg_rdata;
    @(negedge clk);
    cfg_rd = 1'b0;
  endtask

  task automatic run(input int dir, input logic [W-1:0] st, input int n, input int stall, input bit tamper);
    logic [W-1:0] rd;
    logic [3:0] dv;
    int t;
    run_dir = dir; run_start = st; run_n = n; nstb = 0;
    dv = 4'(run_k);
    cfg_write(2'd1, st);
    cfg_write(2'd2, 8'(n));
    cfg_read(2'd1, rd); chk(rd == st, "R2 address readback", rd, st);
    cfg_read(2'd2, rd); chk(rd == 8'(n), "R2 count readback", rd, n);
    cfg_write(2'd0, {2'b00, dv, 1'b1, 1'(dir)});
    chk(dev_sel == dv, "R2 device select", dev_sel, dv);
    fork
      if (dir == 0) begin
        for (int i = 0; i < n; i++) begin
          repeat (stall) @(negedge clk);
          dev_in_valid = 1'b1; dev_in_data = pat(run_k, i);
          while (!dev_in_ready) @(negedge clk);
          @(negedge clk);
          dev_in_valid = 1'b0;
          chk(!dev_in_ready, "R6 in-ready low while full", int'(dev_in_ready), 0);
        end
      end else begin
        for (int i = 0; i < n; i++) begin
          logic [W-1:0] ex;
          while (!dev_out_valid) @(negedge clk);
          ex = mem[8'(st + i)];
          for (int s = 0; s < stall; s++) begin
            chk(!bus_req, "R6 no request while word waits", int'(bus_req), 0);
            @(negedge clk);
            chk(dev_out_valid && dev_out_data == ex, "R6 hold", dev_out_data, ex);
          end
          dev_out_ready = 1'b1;
          chk(dev_out_data == ex, "R5 device data", dev_out_data, ex);
          rx_cyc = cyc;
          @(negedge clk);
          dev_out_ready = 1'b0;
        end
      end
      if (tamper) begin
        logic [W-1:0] r2;
        while (nstb < 1) @(negedge clk);
        cfg_write(2'd1, 8'h55);
        cfg_write(2'd2, 8'd9);
        cfg_write(2'd0, 8'h03);
        cfg_read(2'd0, r2);
        chk(r2[0] == 1'b1, "R10 still busy", r2, 1);
      end
    join
    t = 0;
    while (!irq && t < 60) begin @(negedge clk); t++; end
    chk(cyc == (dir == 0 ? stb_cyc : rx_cyc) + 2, "R8 irq timing", cyc, (dir == 0 ? stb_cyc : rx_cyc) + 2);
    chk(nstb == n, "R4/R5 word count", nstb, n);
    cfg_read(2'd0, rd); chk(rd == 8'h02, "R8 status with irq", rd, 2);
    cfg_read(2'd0, rd); chk(rd == 8'h00, "R8 irq cleared", rd, 0);
    chk(!irq, "R8 irq pin cleared", int'(irq), 0);
    cfg_read(2'd1, rd); chk(rd == 8'(st + n), "R7 final address", rd, 8'(st + n));
    cfg_read(2'd2, rd); chk(rd == 8'd0, "R7 final count", rd, 0);
    if (tamper) chk(dev_sel == dv, "R10 device select unchanged", dev_sel, dv);
    if (dir == 0)
      for (int i = 0; i < n; i++)
        chk(mem[8'(st + i)] == pat(run_k, i), "R4 memory content", mem[8'(st + i)], pat(run_k, i));
    run_k++;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [W-1:0] rd;
    int starts [2];
    int lens [3];
    starts[0] = 8'h10; starts[1] = 8'hFD;
    lens[0] = 1; lens[1] = 3; lens[2] = 6;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!irq && !bus_req && !dev_in_ready && !dev_out_valid, "R1 reset outputs",
        {irq, bus_req, dev_in_ready, dev_out_valid}, 0);
    for (int a = 0; a < 3; a++) begin
      cfg_read(2'(a), rd);
      chk(rd == 0, "R1 reset readback", rd, 0);
    end

    // R9: zero-length start
    cfg_write(2'd2, 8'd0);
    cfg_write(2'd0, 8'h02);
    chk(irq && !bus_req, "R9 immediate irq", {irq, bus_req}, 2);
    cfg_read(2'd0, rd); chk(rd == 8'h02, "R9 not busy", rd, 2);
    repeat (3) @(negedge clk);
    chk(!bus_req && !irq, "R9 no bus request", {bus_req, irq}, 0);

    for (int d = 0; d < 2; d++)
      for (int s = 0; s < 2; s++)
        for (int l = 0; l < 3; l++)
          for (int g = 0; g < 3; g++) begin
            gdly = g;
            run(d, 8'(starts[s]), lens[l], (g % 2) * 2, 1'b0);
          end

    // R10: writes during a run are ignored
    gdly = 1;
    run(0, 8'h40, 5, 1, 1'b1);
    run(1, 8'h80, 4, 2, 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule